// File: doc/BRIEF.md
# Tick Compare Timer Unit

This unit keeps three free-running counters for a processor core: a cycle tick, a system tick and a hypervisor system tick. Each counter is paired with a compare register. A compare register holds a target count and a flag that blocks the interrupt. When a counter becomes equal to its target and the flag is clear, the unit raises a one-cycle timer interrupt pulse.

A tick or system-tick match also sets a sticky bit in a software-interrupt word. That bit stays set until an external clear strobe removes it. A hypervisor match raises only the pulse and leaves the software-interrupt word alone.

The core's register-access logic drives the write ports and reads the counts. Instruction decode is outside this unit.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset every counter is zero, every compare register holds target zero with its interrupt-block flag set, both software-interrupt bits are 0 and the timer pulse is 0. A counter that wraps through zero therefore raises nothing until its compare register is rewritten.
- R2: Each counter advances by exactly one on every clock. From the all-ones value 2^CNT_W-1 it returns to zero.
- R3: When `cnt_wr_en[i]` is high at a clock edge, counter i holds `cnt_wr_data` after that edge, in place of the increment. Index 0 is tick, 1 is system tick and 2 is hypervisor tick.
- R4: Each count output is CNT_W+1 bits wide, its top bit is always 0 and the lower bits carry the live count.
- R5: A compare write through `cmp_wr_en[i]` stores `cmp_wr_data`. Bit CNT_W (bit 63 by default) is the interrupt-block flag, where 1 means blocked. Bits CNT_W-1:0 are the target.
- R6: If the tick counter equals its target while unblocked, then one clock later `timer_irq_o` is high for exactly one cycle and `softint_tick_o` becomes 1.
- R7: If the system tick counter equals its target while unblocked, then one clock later `timer_irq_o` pulses for one cycle and `softint_stick_o` becomes 1.
- R8: If the hypervisor counter equals its target while unblocked, then one clock later `timer_irq_o` pulses for one cycle and neither software-interrupt bit changes.
- R9: A match on a counter whose block flag is set produces no pulse and sets no software-interrupt bit.
- R10: A software-interrupt bit stays 1 until its clear strobe is high at a clock edge: `softint_clr[0]` clears tick and `softint_clr[1]` clears system tick. If a set and a clear of the same bit meet at one edge, the set wins.
- R11: A match is taken once per equality event, when equality begins. Equality that holds over several cycles gives one pulse, and matches on several counters in the same cycle merge into one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 3 | Per-counter load strobe (0 tick, 1 system, 2 hypervisor) |
| cnt_wr_data | input | CNT_W | Count to load |
| cmp_wr_en | input | 3 | Per-compare-register write strobe |
| cmp_wr_data | input | CNT_W+1 | Compare word: block flag on top, target below |
| softint_clr | input | 2 | Clear strobes for the tick and system-tick bits |
| tick_count_o | output | CNT_W+1 | Live tick count, top bit zero |
| stick_count_o | output | CNT_W+1 | Live system tick count, top bit zero |
| hstick_count_o | output | CNT_W+1 | Live hypervisor tick count, top bit zero |
| softint_tick_o | output | 1 | Sticky tick software-interrupt bit |
| softint_stick_o | output | 1 | Sticky system-tick software-interrupt bit |
| timer_irq_o | output | 1 | One-cycle timer interrupt pulse |

## Verification
A tick match that sets the software-interrupt bit can fall in the same cycle as the clear strobe for that bit. The bench places the target three counts ahead of a freshly loaded counter and raises `softint_clr[0]` in exactly the cycle of equality. The bit must read 1 afterwards, stay 1 while no strobe is given, and drop to 0 one clock after a clear in a quiet cycle. The bench also lines up all three matches in one cycle and expects a single pulse with both software-interrupt bits set.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int DEF_CNT_W = 63;
    localparam int NUM_TMR   = 3;
    localparam int SOFT_W    = 2;

    typedef enum logic [1:0] {
        TMR_TICK   = 2'd0,
        TMR_STICK  = 2'd1,
        TMR_HSTICK = 2'd2
    } tmr_sel_e;

    typedef struct packed {
        logic hit;    // equality began this cycle
        logic armed;  // block flag clear
    } match_t;

    // Only the two lower-privilege timers post into the software-interrupt word.
    function automatic logic feeds_softint(int idx);
        return idx != int'(TMR_HSTICK);
    endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIMIT = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_en) begin
            count <= wr_val;
        end else if (count == LIMIT) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tick_compare.sv
module tick_compare
    import tick_pkg::*;
#(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W:0]   wr_word,
    input  logic [CNT_W-1:0] count,
    output match_t           ev
);
    logic             block_q;
    logic [CNT_W-1:0] target_q;
    logic             eq_q;
    logic             eq_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            block_q  <= 1'b1;
            target_q <= '0;
        end else if (wr_en) begin
            block_q  <= wr_word[CNT_W];
            target_q <= wr_word[CNT_W-1:0];
        end
    end

    assign eq_now = (count == target_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_q <= 1'b0;
        end else begin
            eq_q <= eq_now;
        end
    end

    assign ev.hit   = eq_now & ~eq_q;
    assign ev.armed = ~block_q;
endmodule

// File: rtl/tick_irq_merge.sv
module tick_irq_merge
    import tick_pkg::*;
#(
    parameter int NUM = NUM_TMR,
    parameter int SW  = SOFT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  match_t [NUM-1:0]     ev,
    input  logic   [SW-1:0]      soft_clr,
    output logic   [SW-1:0]      soft_q,
    output logic                 irq_q
);
    logic [NUM-1:0] fire;
    logic [SW-1:0]  soft_set;

    for (genvar i = 0; i < NUM; i++) begin : g_fire
        assign fire[i] = ev[i].hit & ev[i].armed;
        if (feeds_softint(i)) begin : g_soft
            assign soft_set[i] = fire[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            soft_q <= soft_set | (soft_q & ~soft_clr);
            irq_q  <= |fire;
        end
    end
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
    import tick_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_TMR-1:0]   cnt_wr_en,
    input  logic [CNT_W-1:0]     cnt_wr_data,
    input  logic [NUM_TMR-1:0]   cmp_wr_en,
    input  logic [CNT_W:0]       cmp_wr_data,
    input  logic [SOFT_W-1:0]    softint_clr,
    output logic [CNT_W:0]       tick_count_o,
    output logic [CNT_W:0]       stick_count_o,
    output logic [CNT_W:0]       hstick_count_o,
    output logic                 softint_tick_o,
    output logic                 softint_stick_o,
    output logic                 timer_irq_o
);
    logic   [CNT_W-1:0]    cnt_val [NUM_TMR];
    match_t [NUM_TMR-1:0]  match_ev;
    logic   [NUM_TMR-1:0]  match_hit;
    logic   [NUM_TMR-1:0]  match_en;
    logic   [SOFT_W-1:0]   soft_bits;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        tick_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (cnt_wr_en[i]),
            .wr_val (cnt_wr_data),
            .count  (cnt_val[i])
        );

        tick_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cmp_wr_en[i]),
            .wr_word (cmp_wr_data),
            .count   (cnt_val[i]),
            .ev      (match_ev[i])
        );

        assign match_hit[i] = match_ev[i].hit;
        assign match_en[i]  = match_ev[i].armed;
    end

    tick_irq_merge #(.NUM(NUM_TMR), .SW(SOFT_W)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .ev       (match_ev),
        .soft_clr (softint_clr),
        .soft_q   (soft_bits),
        .irq_q    (timer_irq_o)
    );

    assign tick_count_o    = {1'b0, cnt_val[TMR_TICK]};
    assign stick_count_o   = {1'b0, cnt_val[TMR_STICK]};
    assign hstick_count_o  = {1'b0, cnt_val[TMR_HSTICK]};
    assign softint_tick_o  = soft_bits[TMR_TICK];
    assign softint_stick_o = soft_bits[TMR_STICK];
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 63
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_wr,
    input logic [CNT_W-1:0] tick_wr_val,
    input logic [CNT_W-1:0] tick_cnt,
    input logic [2:0]       hit,
    input logic [2:0]       en,
    input logic [1:0]       soft_clr,
    input logic             soft_tick,
    input logic             soft_stick,
    input logic             irq
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(tick_wr)) |->
        tick_cnt == (($past(tick_cnt) == TOP) ? '0 : $past(tick_cnt) + 1'b1)); // R2

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(tick_wr)) |-> tick_cnt == $past(tick_wr_val)); // R3

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (irq == $past(|(hit & en)))); // R11

    AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!(|(hit & en)))) |-> !irq); // R9

    AST_TICK_SET: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(hit[0] && en[0])) |-> soft_tick); // R6

    AST_STICK_SET: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(hit[1] && en[1])) |-> soft_stick); // R7

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(soft_tick && !soft_clr[0])) |-> soft_tick); // R10

    AST_STICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(soft_stick && !soft_clr[1])) |-> soft_stick); // R10

    AST_HYP_NO_SOFT: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(hit[2] && !(hit[0] && en[0]) && !soft_tick)) |-> !soft_tick); // R8
endmodule

bind tick_timer_unit tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_wr     (cnt_wr_en[0]),
    .tick_wr_val (cnt_wr_data),
    .tick_cnt    (tick_count_o[CNT_W-1:0]),
    .hit         (match_hit),
    .en          (match_en),
    .soft_clr    (softint_clr),
    .soft_tick   (softint_tick_o),
    .soft_stick  (softint_stick_o),
    .irq         (timer_irq_o)
);

// File: tb/tb_tick_timer_unit.sv
`timescale 1ns/1ps
module tb_tick_timer_unit;
    localparam int CW = 63;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    cnt_wr_en;
    logic [CW-1:0] cnt_wr_data;
    logic [2:0]    cmp_wr_en;
    logic [CW:0]   cmp_wr_data;
    logic [1:0]    softint_clr;
    logic [CW:0]   tick_count_o, stick_count_o, hstick_count_o;
    logic          softint_tick_o, softint_stick_o, timer_irq_o;

    always #10 clk = ~clk;

    tick_timer_unit #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .softint_clr(softint_clr),
        .tick_count_o(tick_count_o), .stick_count_o(stick_count_o),
        .hstick_count_o(hstick_count_o),
        .softint_tick_o(softint_tick_o), .softint_stick_o(softint_stick_o),
        .timer_irq_o(timer_irq_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] count_of(int idx);
        case (idx)
            0:       return tick_count_o;
            1:       return stick_count_o;
            default: return hstick_count_o;
        endcase
    endfunction

    task automatic idle();
        cnt_wr_en   = '0;
        cmp_wr_en   = '0;
        softint_clr = '0;
    endtask

    task automatic clear_soft();
        softint_clr = 2'b11;
        @(negedge clk);
        softint_clr = 2'b00;
        check("R10 cleared tick bit", 64'(softint_tick_o), 64'd0);
        check("R10 cleared stick bit", 64'(softint_stick_o), 64'd0);
    endtask

    // One timer, target d counts ahead of a freshly loaded count.
    task automatic sweep(int idx, bit blk, int d, logic [CW-1:0] base);
        string req;
        bit exp_irq, exp_t, exp_s;
        if (blk)           req = "R5 R9";
        else if (idx == 0) req = "R6";
        else if (idx == 1) req = "R7";
        else               req = "R8";
        @(negedge clk);
        cmp_wr_en   = 3'(1 << idx);
        cmp_wr_data = {blk, base + CW'(d)};
        cnt_wr_en   = 3'(1 << idx);
        cnt_wr_data = base;
        @(negedge clk);
        idle();
        for (int j = 0; j <= d + 3; j++) begin
            if (j > 0) @(negedge clk);
            exp_irq = (j == d + 1) && !blk;
            exp_t   = (j > d) && !blk && (idx == 0);
            exp_s   = (j > d) && !blk && (idx == 1);
            check(req, 64'(timer_irq_o), 64'(exp_irq));
            check(req, 64'(softint_tick_o), 64'(exp_t));
            check(req, 64'(softint_stick_o), 64'(exp_s));
            check("R2 R3 count", count_of(idx), {1'b0, base + CW'(j)});
        end
        clear_soft();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int pulses;
        logic [CW-1:0] base;
        rst = 1'b1;
        idle();
        cnt_wr_data = '0;
        cmp_wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 irq", 64'(timer_irq_o), 64'd0);
        check("R1 tick bit", 64'(softint_tick_o), 64'd0);
        check("R1 stick bit", 64'(softint_stick_o), 64'd0);
        check("R1 equal counts", tick_count_o, stick_count_o);
        check("R1 equal counts", hstick_count_o, stick_count_o);
        check("R1 count after one clock", tick_count_o, 64'd1);

        // R1 R2 R4: wrap through zero against reset compare (target 0, blocked)
        cnt_wr_en   = 3'b111;
        cnt_wr_data = {{(CW-1){1'b1}}, 1'b0};
        @(negedge clk);
        idle();
        for (int j = 0; j <= 5; j++) begin
            if (j > 0) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                if (j == 1) check("R4 top count", count_of(k), 64'h7FFF_FFFF_FFFF_FFFF);
                if (j == 2) check("R2 wrap", count_of(k), 64'd0);
            end
            check("R1 blocked after reset", 64'(timer_irq_o), 64'd0);
            check("R1 no soft bits", 64'({softint_tick_o, softint_stick_o}), 64'd0);
        end

        // Sweep every timer, both flag values, several distances
        for (int idx = 0; idx < 3; idx++)
            for (int blk = 0; blk < 2; blk++)
                for (int d = 1; d <= 5; d++)
                    sweep(idx, blk[0], d, CW'(((idx * 2 + blk) * 8 + d) * 256 + 64'h1_0000));

        // R10: set and clear meet at one edge; set wins
        base = CW'(64'h40_0000);
        @(negedge clk);
        cmp_wr_en   = 3'b001;
        cmp_wr_data = {1'b0, base + CW'(3)};
        cnt_wr_en   = 3'b001;
        cnt_wr_data = base;
        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);       // j = 3, equality cycle
        softint_clr = 2'b01;
        @(negedge clk);                  // j = 4
        softint_clr = 2'b00;
        check("R10 set beats clear", 64'(softint_tick_o), 64'd1);
        check("R6 pulse with collision", 64'(timer_irq_o), 64'd1);
        @(negedge clk);
        check("R10 bit held", 64'(softint_tick_o), 64'd1);
        softint_clr = 2'b01;
        @(negedge clk);
        softint_clr = 2'b00;
        check("R10 clear in quiet cycle", 64'(softint_tick_o), 64'd0);

        // R11: three matches in one cycle merge into one pulse
        base = CW'(64'h50_0000);
        @(negedge clk);
        cmp_wr_en   = 3'b111;
        cmp_wr_data = {1'b0, base + CW'(2)};
        cnt_wr_en   = 3'b111;
        cnt_wr_data = base;
        @(negedge clk);
        idle();
        pulses = 0;
        for (int j = 0; j <= 7; j++) begin
            if (j > 0) @(negedge clk);
            if (timer_irq_o) pulses++;
            if (j == 3) begin
                check("R11 merged pulse", 64'(timer_irq_o), 64'd1);
                check("R11 tick bit", 64'(softint_tick_o), 64'd1);
                check("R11 stick bit", 64'(softint_stick_o), 64'd1);
            end
        end
        check("R11 single merged pulse", 64'(pulses), 64'd1);
        clear_soft();

        // R11: equality held over several cycles gives one pulse
        base = CW'(64'h60_0000);
        @(negedge clk);
        cmp_wr_en   = 3'b001;
        cmp_wr_data = {1'b0, base};
        @(negedge clk);
        idle();
        cnt_wr_en   = 3'b001;
        cnt_wr_data = base;
        pulses = 0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (j == 3) cnt_wr_en = 3'b000;
            if (timer_irq_o) pulses++;
        end
        check("R11 once per event", 64'(pulses), 64'd1);
        clear_soft();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule